// File: doc/BRIEF.md
# Hexadecimal Frame Report Transmitter

This block turns a received 10-byte frame into a line of readable text on an asynchronous serial output. The upstream logic presents the bytes and a flag that says whether the frame was good, then pulses a start request. The block captures both, raises `busy`, and sends the report one character at a time. Every report opens with a carriage return and a line feed. A good frame then follows, byte by byte, as two uppercase hexadecimal characters and a space. A bad frame is followed by a single question mark.

The serial line is driven with inverted polarity, so it can feed a PC serial port directly without a level-inverting buffer. A start bit is high, a data one is low, a data zero is high, and the stop bits and the idle line are low. Each character has one start bit, eight data bits sent least significant bit first, and two stop bits. A cycle divider sets the bit period. The default of 1250 clocks gives 9600 bit/s from a 12 MHz clock.

Inside, a character sequencer steps through these states: `SQ_IDLE`, `SQ_CR`, `SQ_LF`, `SQ_HI`, `SQ_LO`, `SQ_SP`, `SQ_ERR` and `SQ_DRAIN`. Its transitions are:

- start: `SQ_IDLE` to `SQ_CR`
- CR handed over: `SQ_CR` to `SQ_LF`
- LF handed over, good frame: to `SQ_HI`
- LF handed over, bad frame: to `SQ_ERR`
- high nibble handed over: `SQ_HI` to `SQ_LO`
- low nibble handed over: `SQ_LO` to `SQ_SP`
- space handed over, more bytes left: `SQ_SP` to `SQ_HI`
- space handed over, last byte: `SQ_SP` to `SQ_DRAIN`
- '?' handed over: `SQ_ERR` to `SQ_DRAIN`
- line idle again: `SQ_DRAIN` to `SQ_IDLE`, with `done` pulsed

The sequencer feeds a line serializer. The serializer's states are `LN_IDLE`, `LN_START`, `LN_DATA` and `LN_STOP`, with these transitions:

- load: `LN_IDLE` to `LN_START`
- bit tick: `LN_START` to `LN_DATA`
- eighth data tick: `LN_DATA` to `LN_STOP`
- last stop tick: `LN_STOP` to `LN_IDLE`

Top module: `hex_report_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `txd` is low and `done` is low.
- R2: Each character is framed as follows: the start bit drives `txd` high; eight data bits follow, least significant bit first, with a 1 driving `txd` low and a 0 driving it high; two stop bits drive `txd` low.
- R3: Every bit lasts exactly `CLKS_PER_BIT` clock cycles. One idle-low cycle separates consecutive characters, so a report of K characters keeps `busy` high for K*(11*CLKS_PER_BIT+1)+1 cycles.
- R4: Every report begins with 0x0D, then 0x0A.
- R5: When `frame_ok`=1, bytes are reported in index order 0 to NUM_BYTES-1. Byte i is `frame_data[8i+7:8i]`. Each byte is sent as its high-nibble character, then its low-nibble character, then 0x20.
- R6: A nibble value n from 0 to 9 is sent as 0x30+n. A nibble value from 10 to 15 is sent as 0x37+n, which gives 'A' to 'F'.
- R7: When `frame_ok`=0, the report is 0x0D, 0x0A, 0x3F and nothing else.
- R8: `busy` rises in the cycle after `start` is sampled while idle. `done` is high for exactly one cycle, the last cycle in which `busy` is high.
- R9: A `start` pulse while `busy` is high is ignored, and the report in progress is sent unchanged.
- R10: `frame_data` and `frame_ok` are captured when `start` is accepted. Changing them during a report has no effect on its characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Report request, sampled while idle |
| frame_ok | input | 1 | 1: report the bytes; 0: report '?' |
| frame_data | input | NUM_BYTES*8 | Frame bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Report in progress |
| done | output | 1 | One-cycle pulse ending the report |
| txd | output | 1 | Inverted-polarity serial line |

## Verification
The bench builds the block with `CLKS_PER_BIT`=4 and keeps the defaults of ten bytes and two stop bits. With this short bit period, a full 32-character report takes about 1400 cycles. That leaves room for random frames and error reports alongside directed bytes that cover every nibble boundary (0x09/0x0A, 0x00, 0xFF). The bench decodes the line at bit centres and checks each stop bit. It compares the exact `busy` length and the position of `done` against the cycle formula. Starts during a report and scrambled inputs are applied mid-report to show that the captured frame is used.

// File: rtl/hexrpt_pkg.sv
package hexrpt_pkg;

    typedef logic [7:0] octet_t;

    localparam octet_t ASC_CR = 8'h0D;
    localparam octet_t ASC_LF = 8'h0A;
    localparam octet_t ASC_SP = 8'h20;
    localparam octet_t ASC_QM = 8'h3F;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CR,
        SQ_LF,
        SQ_HI,
        SQ_LO,
        SQ_SP,
        SQ_ERR,
        SQ_DRAIN
    } seq_state_e;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_state_e;

    // Hex digit to ASCII: 0..9 -> '0'..'9', 10..15 -> 'A'..'F'
    function automatic octet_t nib_char(input logic [3:0] n);
        if (n < 4'd10)
            return 8'h30 + {4'h0, n};
        else
            return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/hexrpt_baud.sv
module hexrpt_baud #(
    parameter int CLKS_PER_BIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/hexrpt_char_tx.sv
module hexrpt_char_tx
    import hexrpt_pkg::*;
#(
    parameter int CLKS_PER_BIT = 1250,
    parameter int STOP_BITS    = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  octet_t char_in,
    output logic   ready,
    output logic   txd
);
    localparam logic [3:0] DATA_LAST = 4'd7;
    localparam logic [3:0] STOP_LAST = 4'(STOP_BITS - 1);

    line_state_e state_q, state_d;
    octet_t      sh_q, sh_d;
    logic [3:0]  bit_q, bit_d;
    logic        bit_tick;

    hexrpt_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != LN_IDLE),
        .tick  (bit_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            sh_q    <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            bit_q   <= bit_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        bit_d   = bit_q;
        unique case (state_q)
            LN_IDLE: begin
                if (load) begin
                    state_d = LN_START;
                    sh_d    = char_in;
                    bit_d   = '0;
                end
            end
            LN_START: begin
                if (bit_tick) begin
                    state_d = LN_DATA;
                    bit_d   = '0;
                end
            end
            LN_DATA: begin
                if (bit_tick) begin
                    sh_d = {1'b0, sh_q[7:1]};
                    if (bit_q == DATA_LAST) begin
                        state_d = LN_STOP;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            LN_STOP: begin
                if (bit_tick) begin
                    if (bit_q == STOP_LAST) begin
                        state_d = LN_IDLE;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            default: state_d = LN_IDLE;
        endcase
    end

    // Output process: inverted line levels
    always_comb begin
        unique case (state_q)
            LN_START: txd = 1'b1;
            LN_DATA:  txd = ~sh_q[0];
            default:  txd = 1'b0;
        endcase
        ready = (state_q == LN_IDLE);
    end

    // R2: a new character is only taken while the line is idle
    p_load_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == LN_IDLE));

    // R3: the serializer only moves on a bit tick or a load
    p_state_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !load) |=> $stable(state_q));

endmodule

// File: rtl/hexrpt_seq.sv
module hexrpt_seq
    import hexrpt_pkg::*;
#(
    parameter int NUM_BYTES = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   frame_ok,
    input  logic [NUM_BYTES*8-1:0] frame_data,
    input  logic                   tx_ready,
    output logic                   load,
    output octet_t                 char_out,
    output logic                   busy,
    output logic                   done
);
    localparam int IW = (NUM_BYTES > 2) ? $clog2(NUM_BYTES) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(NUM_BYTES - 1);

    seq_state_e    state_q, state_d;
    logic          ok_q;
    logic [IW-1:0] idx_q, idx_d;
    octet_t        data_q [NUM_BYTES];
    octet_t        cur_byte;
    logic          take;

    assign take = (state_q == SQ_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (take)
                ok_q <= frame_ok;
        end
    end

    // Frame capture, one register per byte
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_q[g] <= '0;
            else if (take)
                data_q[g] <= frame_data[8*g +: 8];
        end
    end

    assign cur_byte = data_q[idx_q];

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d = SQ_CR;
                    idx_d   = '0;
                end
            end
            SQ_CR:  if (tx_ready) state_d = SQ_LF;
            SQ_LF:  if (tx_ready) state_d = ok_q ? SQ_HI : SQ_ERR;
            SQ_HI:  if (tx_ready) state_d = SQ_LO;
            SQ_LO:  if (tx_ready) state_d = SQ_SP;
            SQ_SP: begin
                if (tx_ready) begin
                    if (idx_q == IDX_LAST) begin
                        state_d = SQ_DRAIN;
                    end else begin
                        state_d = SQ_HI;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            SQ_ERR:   if (tx_ready) state_d = SQ_DRAIN;
            SQ_DRAIN: if (tx_ready) state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        load     = 1'b0;
        char_out = ASC_CR;
        done     = 1'b0;
        busy     = (state_q != SQ_IDLE);
        unique case (state_q)
            SQ_IDLE:  ;
            SQ_CR:    begin load = tx_ready; char_out = ASC_CR; end
            SQ_LF:    begin load = tx_ready; char_out = ASC_LF; end
            SQ_HI:    begin load = tx_ready; char_out = nib_char(cur_byte[7:4]); end
            SQ_LO:    begin load = tx_ready; char_out = nib_char(cur_byte[3:0]); end
            SQ_SP:    begin load = tx_ready; char_out = ASC_SP; end
            SQ_ERR:   begin load = tx_ready; char_out = ASC_QM; end
            SQ_DRAIN: done = tx_ready;
            default:  ;
        endcase
    end

    // R8: done is a single-cycle pulse
    p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: after done the sequencer is idle
    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/hex_report_tx.sv
module hex_report_tx
    import hexrpt_pkg::*;
#(
    parameter int CLKS_PER_BIT = 1250,
    parameter int NUM_BYTES    = 10,
    parameter int STOP_BITS    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   frame_ok,
    input  logic [NUM_BYTES*8-1:0] frame_data,
    output logic                   busy,
    output logic                   done,
    output logic                   txd
);
    logic   tx_ready;
    logic   tx_load;
    octet_t tx_char;

    hexrpt_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_ok   (frame_ok),
        .frame_data (frame_data),
        .tx_ready   (tx_ready),
        .load       (tx_load),
        .char_out   (tx_char),
        .busy       (busy),
        .done       (done)
    );

    hexrpt_char_tx #(
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .STOP_BITS    (STOP_BITS)
    ) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .char_in (tx_char),
        .ready   (tx_ready),
        .txd     (txd)
    );

    // R1: the line rests low whenever no report is running
    p_idle_line_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !txd);

    // R9: a start during a report does not end or restart it
    p_start_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);

endmodule

// File: tb/hex_report_tx_tb_top.sv
module hex_report_tx_tb_top;

    localparam int C  = 4;
    localparam int NB = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          frame_ok = 1'b0;
    logic [NB*8-1:0] fdata = '0;
    logic          busy, done, txd;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] exp_c [0:63];
    int         exp_n;
    logic [7:0] rx_c  [0:63];
    int         rx_n = 0;

    always #10 clk = ~clk;

    hex_report_tx #(.CLKS_PER_BIT(C), .NUM_BYTES(NB), .STOP_BITS(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_ok   (frame_ok),
        .frame_data (fdata),
        .busy       (busy),
        .done       (done),
        .txd        (txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] hexdig(input logic [3:0] n);
        return (n < 10) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
    endfunction

    task automatic build_expect(input bit ok, input logic [NB*8-1:0] d);
        exp_c[0] = 8'h0D;
        exp_c[1] = 8'h0A;
        if (ok) begin
            for (int i = 0; i < NB; i++) begin
                exp_c[2+3*i] = hexdig(d[8*i+4 +: 4]);
                exp_c[3+3*i] = hexdig(d[8*i +: 4]);
                exp_c[4+3*i] = 8'h20;
            end
            exp_n = 2 + 3*NB;
        end else begin
            exp_c[2] = 8'h3F;
            exp_n = 3;
        end
    endtask

    // Line monitor: decodes inverted characters at bit centres (R2)
    initial begin
        logic prev;
        logic [7:0] ch;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && txd && !prev) begin
                repeat (C/2) @(negedge clk);
                check(txd == 1'b1, "R2 start bit high", txd, 1);
                for (int b = 0; b < 8; b++) begin
                    repeat (C) @(negedge clk);
                    ch[b] = ~txd;
                end
                for (int s = 0; s < 2; s++) begin
                    repeat (C) @(negedge clk);
                    check(txd == 1'b0, "R2 stop bit low", txd, 0);
                end
                if (rx_n < 64) rx_c[rx_n] = ch;
                rx_n++;
            end
            prev = txd;
        end
    end

    task automatic run_report(input bit ok, input logic [NB*8-1:0] d,
                              input bit inject, input bit scramble);
        int cyc, done_cnt, done_at, total;
        build_expect(ok, d);
        rx_n = 0;
        @(negedge clk);
        fdata = d; frame_ok = ok; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        cyc = 0; done_cnt = 0; done_at = -1;
        while (busy && cyc < 5000) begin
            cyc++;
            if (done) begin done_cnt++; done_at = cyc; end
            if (scramble) begin
                for (int w = 0; w < NB; w++) fdata[8*w +: 8] = 8'($urandom);
                frame_ok = ~frame_ok;
            end
            start = (inject && (cyc == 50 || cyc == 51));
            if (inject && cyc == 50) frame_ok = ~ok;
            @(negedge clk);
        end
        start = 1'b0;
        total = exp_n * (11*C + 1) + 1;
        check(cyc == total, "R3 busy length", cyc, total);
        check(done_cnt == 1 && done_at == total, "R8 done last busy cycle", done_at, total);
        repeat (6) @(negedge clk);
        check(txd == 1'b0 && done == 1'b0, "R1 idle after report", txd, 0);
        check(rx_n == exp_n, ok ? "R5 char count" : "R7 char count", rx_n, exp_n);
        for (int k = 0; k < exp_n && k < rx_n; k++) begin
            string tag;
            if (k < 2) tag = "R4 CR/LF";
            else if (!ok) tag = "R7 error token";
            else if ((k - 2) % 3 == 2) tag = "R5 space";
            else tag = "R6 hex digit";
            if (inject) tag = {tag, " R9"};
            if (scramble) tag = {tag, " R10"};
            check(rx_c[k] == exp_c[k], tag, rx_c[k], exp_c[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NB*8-1:0] d;
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        check(txd == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset state", {txd, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(txd == 1'b0 && busy == 1'b0, "R1 idle after reset", {txd, busy}, 0);

        // Directed nibble boundaries (R6)
        d = {8'h5C, 8'hFF, 8'hF0, 8'hA9, 8'h9A, 8'h10, 8'h0F, 8'h0A, 8'h09, 8'h00};
        run_report(1'b1, d, 1'b0, 1'b0);
        // Error report (R7)
        run_report(1'b0, d, 1'b0, 1'b0);
        // Start while busy ignored (R9)
        run_report(1'b1, d, 1'b1, 1'b0);
        run_report(1'b0, d, 1'b1, 1'b0);
        // Inputs captured at start (R10)
        for (int w = 0; w < NB; w++) d[8*w +: 8] = 8'($urandom);
        run_report(1'b1, d, 1'b0, 1'b1);
        // Random reports
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < NB; w++) d[8*w +: 8] = 8'($urandom);
            run_report(($urandom % 4) != 0, d, 1'b0, 1'b0);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule